// File: doc/BRIEF.md
# Fractional PLL Divider Search Engine

This block works out the divider settings that bring a fractional-N PLL closest to a requested output frequency. Each request carries the wanted rate, the reference frequency and the divider settings now in use. The block returns an integer feedback multiplier M, a predivider P, a postdivider exponent S and a signed fractional term K, together with the rate those settings give. The rate is (M·65536 + K)·Fin / (P·65536·2^S).

Three stages run in turn. The first looks for the request in a small built-in preset list. The second tries to reach the rate by moving only K, with M, P and S left as they are, so the loop can be retuned without relock. The third sweeps P and S, derives M and K for each pair and keeps the closest result. One operand multiplier and one iterative restoring divider, 64 bits wide, carry all the arithmetic in sequence. Software or a sequencer raises `start` for one cycle and reads the results while `done` is high.

Top module: `fpll_div_search`

## Requirements
- R1: When the request equals a preset rate, that preset's settings are returned unchanged, `res_rate` equals the request and `res_stage` is 1. Presets as (rate: M, P, S, K): 650000000: 325, 3, 2, 0; 594000000: 198, 2, 2, 0; 393216000: 262, 2, 3, 9437; 1039500000: 173, 2, 1, 16384. `done` rises two clocks after the `start` edge.
- R2: In stages 2 and 3, `res_rate` = floor(Fin·(M·65536 + K) / ((P·65536)·2^S)) for the returned settings.
- R3: If no preset matches and the request lies inclusively between the rates of the current M, P, S with K = −32768 and with K = 32767, then M, P, S are returned equal to the current values and `res_stage` is 2.
- R4: K = floor((request·P·65536·2^S + floor(Fin/2)) / Fin) − M·65536, saturated to −32768..32767.
- R5: Otherwise P runs from 1 to 7 (outer) and S from 0 to 6 (inner). The candidate with the smallest |request − rate| is kept, an equal error never replaces an earlier one, and `res_stage` is 3.
- R6: In the sweep, M = floor((request·P·2^S + floor(Fin/2)) / Fin), clamped to 64..1023.
- R7: The sweep stops at the first candidate with zero error.
- R8: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted `start` until `done`, and low while `done` is high.
- R9: After reset, `done` and `busy` are low and `res_stage` is 0.
- R10: A `start` that arrives while `busy` is high is ignored. The running search finishes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| req_rate | input | 32 | Requested output rate, Hz |
| ref_rate | input | 32 | Reference input rate, Hz (nonzero) |
| cur_m | input | 10 | Current multiplier |
| cur_p | input | 6 | Current predivider (nonzero) |
| cur_s | input | 3 | Current postdivider exponent |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid pulse |
| res_m | output | 10 | Result multiplier |
| res_p | output | 6 | Result predivider |
| res_s | output | 3 | Result postdivider exponent |
| res_k | output | 16 | Result fractional term, signed |
| res_rate | output | 32 | Rate reached by the result |
| res_stage | output | 2 | 1 preset, 2 fraction only, 3 sweep |

## Verification
A preset hit is due exactly two clocks after the `start` edge. Every other result takes a variable number of cycles. Each division costs 66 cycles: two precede the fraction-only attempt, that attempt adds two more, and the sweep adds three per (P, S) pair. For that reason the bench waits for `done`, sampling at the falling edge, and counts the cycles. It checks the preset latency exactly and checks sweep latency only against bounds, since a first-pair exact hit ends far sooner than a full 49-pair sweep. It also checks that `done` is gone one cycle later.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int MW = 10;
  localparam int PW = 6;
  localparam int SW = 3;
  localparam int KW = 16;
  localparam int RW = 32;
  localparam int XW = 64;
  localparam int M_MIN = 64;
  localparam int M_MAX = 1023;
  localparam int N_PRESET = 4;

  typedef enum logic [1:0] {SRC_NONE, SRC_TABLE, SRC_FRAC, SRC_SWEEP} src_e;
  typedef enum logic [1:0] {OP_RATE, OP_KDIV, OP_MDIV} op_e;

  typedef struct packed {
    logic [RW-1:0]        rate;
    logic [MW-1:0]        m;
    logic [PW-1:0]        p;
    logic [SW-1:0]        s;
    logic signed [KW-1:0] k;
  } preset_t;

  function automatic preset_t preset_at(input int idx);
    preset_t e;
    e = '0;
    case (idx)
      0: e = '{rate: 32'd650000000,  m: 10'd325, p: 6'd3, s: 3'd2, k: 16'sd0};
      1: e = '{rate: 32'd594000000,  m: 10'd198, p: 6'd2, s: 3'd2, k: 16'sd0};
      2: e = '{rate: 32'd393216000,  m: 10'd262, p: 6'd2, s: 3'd3, k: 16'sd9437};
      3: e = '{rate: 32'd1039500000, m: 10'd173, p: 6'd2, s: 3'd1, k: 16'sd16384};
      default: e = '0;
    endcase
    return e;
  endfunction

  // saturate a wide signed value into the fractional term range
  function automatic logic signed [KW-1:0] sat_k(input logic signed [XW-1:0] v);
    if (v > 64'sd32767)  return 16'sh7fff;
    if (v < -64'sd32768) return 16'sh8000;
    return $signed(v[KW-1:0]);
  endfunction

  function automatic logic [MW-1:0] clamp_m(input logic [XW-1:0] v);
    if (v < XW'(M_MIN)) return MW'(M_MIN);
    if (v > XW'(M_MAX)) return MW'(M_MAX);
    return v[MW-1:0];
  endfunction

  function automatic logic [XW-1:0] abs_diff(input logic [XW-1:0] a, input logic [XW-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/fps_divu.sv
module fps_divu #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  rem_n;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    fits  = trial >= {1'b0, den_q};
    rem_n = fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && cnt_q == '0) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= rem_n;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign quo  = quo_q;
  assign busy = cnt_q != '0;

  // R2: the shared divider is never relaunched mid-division
  a_r2_div_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy);
  a_r2_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: rtl/fps_preset.sv
module fps_preset import fps_pkg::*; #(
  parameter int N = N_PRESET
) (
  input  logic [RW-1:0] req,
  output logic          hit,
  output preset_t       entry
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    localparam preset_t E = preset_at(i);
    assign match[i] = (E.rate == req);
  end

  always_comb begin
    hit   = |match;
    entry = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) entry = preset_at(i);
  end
endmodule

// File: rtl/fps_opgen.sv
module fps_opgen import fps_pkg::*; (
  input  op_e                  op,
  input  logic [RW-1:0]        req,
  input  logic [RW-1:0]        fin,
  input  logic [MW-1:0]        m,
  input  logic [PW-1:0]        p,
  input  logic [SW-1:0]        s,
  input  logic signed [KW-1:0] k,
  output logic [XW-1:0]        num,
  output logic [XW-1:0]        den
);
  logic [XW-1:0] mul_a, mul_b, prod;
  logic [XW-1:0] p_scaled, p_shift, m_frac, half_fin;

  always_comb begin
    p_shift  = XW'(p) << s;
    p_scaled = (XW'(p) << 16) << s;
    m_frac   = (XW'(m) << 16) + XW'($signed(k));
    half_fin = XW'(fin >> 1);
    mul_a    = XW'(req);
    mul_b    = p_shift;
    num      = '0;
    den      = XW'(fin);
    case (op)
      OP_RATE: begin
        mul_a = XW'(fin);
        mul_b = m_frac;
        den   = p_scaled;
      end
      OP_KDIV: mul_b = p_scaled;
      default: mul_b = p_shift;
    endcase
    prod = mul_a * mul_b;
    num  = (op == OP_RATE) ? prod : prod + half_fin;
  end
endmodule

// File: rtl/fpll_div_search.sv
module fpll_div_search import fps_pkg::*; #(
  parameter int P_MAX = 7,
  parameter int S_MAX = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [RW-1:0]        req_rate,
  input  logic [RW-1:0]        ref_rate,
  input  logic [MW-1:0]        cur_m,
  input  logic [PW-1:0]        cur_p,
  input  logic [SW-1:0]        cur_s,
  output logic                 busy,
  output logic                 done,
  output logic [MW-1:0]        res_m,
  output logic [PW-1:0]        res_p,
  output logic [SW-1:0]        res_s,
  output logic signed [KW-1:0] res_k,
  output logic [RW-1:0]        res_rate,
  output logic [1:0]           res_stage
);
  localparam logic [PW-1:0] P_LAST = PW'(P_MAX);
  localparam logic [SW-1:0] S_LAST = SW'(S_MAX);

  typedef enum logic [3:0] {ST_IDLE, ST_TBL, ST_LO, ST_HI, ST_FK, ST_FR, ST_SM, ST_SK, ST_SR} st_e;

  st_e state;
  logic [RW-1:0] req_q, fin_q;
  logic [MW-1:0] cm_q, m_w;
  logic [PW-1:0] cp_q, p_w;
  logic [SW-1:0] cs_q, s_w;
  logic signed [KW-1:0] k_w;
  logic [XW-1:0] lo_q, best_dist;
  logic launched;

  // operand selection for the shared multiplier and divider
  op_e op;
  logic [MW-1:0] op_m;
  logic [PW-1:0] op_p;
  logic [SW-1:0] op_s;
  logic signed [KW-1:0] op_k;
  logic [XW-1:0] div_num, div_den, div_quo;
  logic div_start, div_done, div_busy, div_state;

  // named events for assertions and readability
  logic tbl_hit;
  preset_t tbl_entry;
  logic [XW-1:0] req_x, cand_dist;
  logic in_window, better, exact, last_pair;
  logic signed [KW-1:0] k_calc;
  logic [MW-1:0] m_calc;

  always_comb begin
    op   = OP_RATE;
    op_m = cm_q;
    op_p = cp_q;
    op_s = cs_q;
    op_k = '0;
    div_state = 1'b1;
    case (state)
      ST_LO: op_k = 16'sh8000;
      ST_HI: op_k = 16'sh7fff;
      ST_FK: op = OP_KDIV;
      ST_FR: op_k = k_w;
      ST_SM: begin op = OP_MDIV; op_p = p_w; op_s = s_w; end
      ST_SK: begin op = OP_KDIV; op_m = m_w; op_p = p_w; op_s = s_w; end
      ST_SR: begin op_m = m_w; op_p = p_w; op_s = s_w; op_k = k_w; end
      default: div_state = 1'b0;
    endcase
  end

  fps_opgen u_opgen (
    .op(op), .req(req_q), .fin(fin_q), .m(op_m), .p(op_p), .s(op_s), .k(op_k),
    .num(div_num), .den(div_den)
  );

  assign div_start = div_state && !launched && !div_busy;

  fps_divu #(.W(XW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
    .quo(div_quo), .done(div_done), .busy(div_busy)
  );

  fps_preset #(.N(N_PRESET)) u_preset (.req(req_q), .hit(tbl_hit), .entry(tbl_entry));

  always_comb begin
    req_x     = XW'(req_q);
    in_window = (req_x >= lo_q) && (req_x <= div_quo);
    k_calc    = sat_k($signed(div_quo) - $signed({{(XW-MW-16){1'b0}}, op_m, 16'b0}));
    m_calc    = clamp_m(div_quo);
    cand_dist = abs_diff(div_quo, req_x);
    better    = cand_dist < best_dist;
    exact     = better && (cand_dist == '0);
    last_pair = (p_w == P_LAST) && (s_w == S_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_q     <= '0;
      fin_q     <= '0;
      cm_q      <= '0;
      cp_q      <= '0;
      cs_q      <= '0;
      m_w       <= '0;
      p_w       <= '0;
      s_w       <= '0;
      k_w       <= '0;
      lo_q      <= '0;
      best_dist <= '1;
      launched  <= 1'b0;
      done      <= 1'b0;
      res_m     <= '0;
      res_p     <= '0;
      res_s     <= '0;
      res_k     <= '0;
      res_rate  <= '0;
      res_stage <= SRC_NONE;
    end else begin
      done <= 1'b0;
      if (div_start) launched <= 1'b1;
      if (div_done)  launched <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          req_q     <= req_rate;
          fin_q     <= ref_rate;
          cm_q      <= cur_m;
          cp_q      <= cur_p;
          cs_q      <= cur_s;
          best_dist <= '1;
          state     <= ST_TBL;
        end
        ST_TBL: if (tbl_hit) begin
          res_m     <= tbl_entry.m;
          res_p     <= tbl_entry.p;
          res_s     <= tbl_entry.s;
          res_k     <= tbl_entry.k;
          res_rate  <= req_q;
          res_stage <= SRC_TABLE;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end else begin
          state <= ST_LO;
        end
        ST_LO: if (div_done) begin
          lo_q  <= div_quo;
          state <= ST_HI;
        end
        ST_HI: if (div_done) begin
          if (in_window) begin
            state <= ST_FK;
          end else begin
            p_w   <= PW'(1);
            s_w   <= '0;
            state <= ST_SM;
          end
        end
        ST_FK: if (div_done) begin
          k_w   <= k_calc;
          state <= ST_FR;
        end
        ST_FR: if (div_done) begin
          res_m     <= cm_q;
          res_p     <= cp_q;
          res_s     <= cs_q;
          res_k     <= k_w;
          res_rate  <= div_quo[RW-1:0];
          res_stage <= SRC_FRAC;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_SM: if (div_done) begin
          m_w   <= m_calc;
          state <= ST_SK;
        end
        ST_SK: if (div_done) begin
          k_w   <= k_calc;
          state <= ST_SR;
        end
        ST_SR: if (div_done) begin
          if (better) begin
            best_dist <= cand_dist;
            res_m     <= m_w;
            res_p     <= p_w;
            res_s     <= s_w;
            res_k     <= k_w;
            res_rate  <= div_quo[RW-1:0];
            res_stage <= SRC_SWEEP;
          end
          if (exact || last_pair) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            if (s_w == S_LAST) begin
              s_w <= '0;
              p_w <= p_w + 1'b1;
            end else begin
              s_w <= s_w + 1'b1;
            end
            state <= ST_SM;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r1_table_path: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_stage == SRC_TABLE) |-> $past(state == ST_TBL));
  a_r3_frac_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_stage == SRC_FRAC) |-> (res_m == cm_q && res_p == cp_q && res_s == cs_q));
  a_r6_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SK) |-> (m_w >= MW'(M_MIN) && m_w <= MW'(M_MAX)));
  a_r5_sweep_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SM) |-> (p_w >= PW'(1) && p_w <= P_LAST && s_w <= S_LAST));
  a_r5_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best_dist <= $past(best_dist)));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(req_q));
endmodule

// File: tb/tb_fpll_div_search.sv
module tb_fpll_div_search;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] req_rate = '0, ref_rate = '0;
  logic [9:0] cur_m = '0;
  logic [5:0] cur_p = '0;
  logic [2:0] cur_s = '0;
  logic busy, done;
  logic [9:0] res_m;
  logic [5:0] res_p;
  logic [2:0] res_s;
  logic signed [15:0] res_k;
  logic [31:0] res_rate;
  logic [1:0] res_stage;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fpll_div_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate), .ref_rate(ref_rate),
    .cur_m(cur_m), .cur_p(cur_p), .cur_s(cur_s), .busy(busy), .done(done),
    .res_m(res_m), .res_p(res_p), .res_s(res_s), .res_k(res_k),
    .res_rate(res_rate), .res_stage(res_stage)
  );

  // stimulus vectors: request, reference, current M/P/S
  localparam int NV = 9;
  localparam longint V_REQ [NV] = '{650000000, 393216000, 650300000, 649000000, 648999999,
                                     100000000, 50000, 650999969, 300000000};
  localparam longint V_FIN [NV] = '{24000000, 24000000, 24000000, 24000000, 24000000,
                                     24000000, 24000000, 24000000, 25000000};
  localparam int V_CM [NV] = '{325, 325, 325, 325, 325, 325, 325, 325, 100};
  localparam int V_CP [NV] = '{3, 3, 3, 3, 3, 3, 3, 3, 1};
  localparam int V_CS [NV] = '{2, 2, 2, 2, 2, 2, 2, 2, 3};

  // preset list as stated in R1
  localparam longint T_RATE [4] = '{650000000, 594000000, 393216000, 1039500000};
  localparam int T_M [4] = '{325, 198, 262, 173};
  localparam int T_P [4] = '{3, 2, 2, 2};
  localparam int T_S [4] = '{2, 2, 3, 1};
  localparam int T_K [4] = '{0, 0, 9437, 16384};

  function automatic longint f_rate(longint fin, longint m, longint p, longint s, longint k);
    return (fin * (m * 65536 + k)) / ((p * 65536) << s);
  endfunction

  function automatic longint f_k(longint rq, longint fin, longint m, longint p, longint s);
    longint q;
    q = (rq * ((p * 65536) << s) + fin / 2) / fin - m * 65536;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  function automatic longint f_m(longint rq, longint fin, longint p, longint s);
    longint q;
    q = (rq * (p << s) + fin / 2) / fin;
    if (q < 64) q = 64;
    if (q > 1023) q = 1023;
    return q;
  endfunction

  task automatic model(input longint rq, input longint fin, input int cm, input int cp, input int cs,
                       output longint em, output longint ep, output longint es, output longint ek,
                       output longint er, output longint est);
    longint lo, hi, best, m, k, r, d;
    bit found;
    for (int i = 0; i < 4; i++) begin
      if (rq == T_RATE[i]) begin
        em = T_M[i]; ep = T_P[i]; es = T_S[i]; ek = T_K[i]; er = rq; est = 1;
        return;
      end
    end
    lo = f_rate(fin, cm, cp, cs, -32768);
    hi = f_rate(fin, cm, cp, cs, 32767);
    if (rq >= lo && rq <= hi) begin
      em = cm; ep = cp; es = cs;
      ek = f_k(rq, fin, cm, cp, cs);
      er = f_rate(fin, cm, cp, cs, ek) & 64'hFFFF_FFFF;
      est = 2;
      return;
    end
    best = 64'h7FFF_FFFF_FFFF_FFFF;
    found = 1'b0;
    em = 0; ep = 0; es = 0; ek = 0; er = 0; est = 3;
    for (int p = 1; p <= 7; p++) begin
      for (int s = 0; s <= 6; s++) begin
        if (!found) begin
          m = f_m(rq, fin, p, s);
          k = f_k(rq, fin, m, p, s);
          r = f_rate(fin, m, p, s, k);
          d = (r > rq) ? r - rq : rq - r;
          if (d < best) begin
            best = d; em = m; ep = p; es = s; ek = k; er = r & 64'hFFFF_FFFF;
            if (d == 0) found = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input longint rq, input longint fin, input int cm, input int cp, input int cs);
    @(negedge clk);
    req_rate = rq[31:0];
    ref_rate = fin[31:0];
    cur_m = cm[9:0];
    cur_p = cp[5:0];
    cur_s = cs[2:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 30000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input longint rq, input longint fin, input int cm, input int cp, input int cs);
    longint em, ep, es, ek, er, est;
    string grp;
    model(rq, fin, cm, cp, cs, em, ep, es, ek, er, est);
    grp = (est == 1) ? "R1" : (est == 2) ? "R3" : "R5";
    chk({grp, " stage"}, res_stage, est);
    chk({grp, " M (R6 clamp in sweep)"}, res_m, em);
    chk({grp, " P"}, res_p, ep);
    chk({grp, " S"}, res_s, es);
    chk({grp, " K (R4 rounding)"}, longint'(res_k), ek);
    chk("R2 rate", res_rate, er);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int lat, lat_early, lat_full;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done at reset", done, 0);
    chk("R9 busy at reset", busy, 0);
    chk("R9 stage at reset", res_stage, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      launch(V_REQ[v], V_FIN[v], V_CM[v], V_CP[v], V_CS[v]);
      chk("R8 busy while running", busy, 1);
      wait_done(lat);
      chk("R8 done seen", done, 1);
      if (v < 2) chk("R1 preset latency", lat, 2);
      check_result(V_REQ[v], V_FIN[v], V_CM[v], V_CP[v], V_CS[v]);
      @(negedge clk);
      chk("R8 done is one cycle", done, 0);
      if (v == 6) lat_full = lat;
    end

    // R3 window boundary: exact low edge uses fraction path with K=-32768
    launch(649000000, 24000000, 325, 3, 2);
    wait_done(lat);
    chk("R3 low edge stage", res_stage, 2);
    chk("R4 saturated low K", longint'(res_k), -32768);

    // R7 early stop: exact candidate on the first (P,S) pair
    launch(1536000000, 24000000, 325, 3, 2);
    wait_done(lat_early);
    check_result(1536000000, 24000000, 325, 3, 2);
    chk("R7 first pair exact M", res_m, 64);
    chk("R7 early finish", (lat_early < 400) ? 1 : 0, 1);
    chk("R7 full sweep longer", (lat_full > 9700) ? 1 : 0, 1);

    // R10 start while busy is ignored
    launch(100000000, 24000000, 325, 3, 2);
    repeat (40) @(negedge clk);
    req_rate = 32'd650000000;
    cur_m = 10'd500;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check_result(100000000, 24000000, 325, 3, 2);
    chk("R10 stage kept", res_stage, 3);
    @(negedge clk);
    chk("R10 no second run", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule